// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block sends 32-bit ARINC 429 words onto a pair of return-to-zero signal lines. A host pushes words into an internal queue of eight entries. When enabled, the channel takes words from the queue in arrival order. It can overwrite the top bit of each word with a computed parity bit. It then shifts the word out least significant bit first. A 1 bit is a pulse on the "one" line and a 0 bit is a pulse on the "zero" line.

Each bit period has two equal halves. The length of a half is set in system clock cycles by a programmable divisor, so the bit rate can be tuned for each channel. After every word the channel holds both lines low for a programmable gap, and that gap is never shorter than four bit periods. The channel reports two conditions. A level shows when the queue holds nothing. A one-cycle pulse marks the end of transmission: the last queued word has finished and no further word is waiting.

Top module: `a429_tx_channel`

## Requirements
- R1: While and after reset, both lines are low, `fifo_empty` is high and `eot` is low.
- R2: For each bit, the selected line is high for one half-bit and then both lines are low for one half-bit. `line_one` pulses for a 1 bit and `line_zero` pulses for a 0 bit. The two lines are never high together.
- R3: The 32 bits of a word leave in index order, starting with bit 0 and ending with bit 31.
- R4: `par_mode` encoding: 2'b00 sends bit 31 as written. 2'b01 replaces bit 31 so that the word carries an odd number of ones. 2'b10 replaces bit 31 so that the word carries an even number of ones. 2'b11 behaves like 2'b00.
- R5: A half-bit lasts `half_len` clock cycles. A value of 0 is treated as 1, so the fastest bit period is two clock cycles.
- R6: When the next word is already queued, the lines stay low between the high half of bit 31 and the first high half of the next word for exactly (2*G+1)*H cycles. H is the half-bit length and G is `gap_len` raised to at least 4.
- R7: The queue holds 8 words and sends them in the order they were written. A write made while the queue is full is dropped.
- R8: `fifo_empty` is high exactly when the queue holds no word. It updates on the clock edge after the write or the removal.
- R9: `eot` is a one-cycle pulse raised after bit 31 of a word completes while the queue is empty. Exactly one pulse occurs per burst of back-to-back words.
- R10: While `en` is low, no new word starts. A word already in progress completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Allows new words to start |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Word to queue |
| par_mode | input | 2 | Parity selection (R4) |
| half_len | input | DIV_W | Half-bit length in clock cycles |
| gap_len | input | GAP_W | Inter-word gap in bit periods (minimum 4) |
| line_one | output | 1 | RZ line that pulses for 1 bits |
| line_zero | output | 1 | RZ line that pulses for 0 bits |
| fifo_empty | output | 1 | Queue holds no word |
| eot | output | 1 | End-of-transmission pulse |

## Verification
The assertions take for granted that `half_len`, `gap_len` and `par_mode` stay constant while a word is on the lines. The half-bit counter bound depends on that, and so do the pulse-width claims. The stimulus changes these settings only after an `eot` pulse, followed by a long idle wait, so each word is generated entirely under one configuration. Writes are issued only on the falling clock edge, and the bench fills the queue past capacity only while `en` is low. This keeps the drop of a write to a full queue separate from any simultaneous removal.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int WORD_W  = 32;
    localparam int MIN_GAP = 4;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_RSVD = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } ser_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] bits;
        logic [4:0]        idx;
    } shift_t;

    // Top bit replaced so the whole word carries the requested ones-count parity.
    function automatic logic [WORD_W-1:0] apply_parity(input logic [WORD_W-1:0] w,
                                                       input par_mode_e m);
        logic [WORD_W-1:0] r;
        r = w;
        case (m)
            PAR_ODD:  r[WORD_W-1] = ~^w[WORD_W-2:0];
            PAR_EVEN: r[WORD_W-1] =  ^w[WORD_W-2:0];
            default:  r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo
    import a429_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [AW:0]       count;
    logic              do_wr, do_rd;

    assign do_rd   = rd_en && (count != '0);
    assign do_wr   = wr_en && ((count != (AW+1)'(DEPTH)) || do_rd);
    assign rd_data = mem[rd_ptr];
    assign empty   = (count == '0);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);

endmodule

// File: rtl/a429_tx_halftimer.sv
module a429_tx_halftimer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             half_end
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff;

    assign eff      = (half_len == '0) ? DIV_W'(1) : half_len;
    assign half_end = run && (cnt == eff - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run)   cnt <= '0;
        else if (half_end) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // R5
    half_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < eff);

endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
    import a429_tx_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              half_end,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] rd_data,
    input  par_mode_e         par_mode,
    input  logic [GAP_W-1:0]  gap_len,
    output logic              pop,
    output logic              running,
    output logic              line_one,
    output logic              line_zero,
    output logic              eot
);
    localparam logic [4:0] LAST_BIT = 5'(WORD_W - 1);

    ser_state_e       state;
    shift_t           sh;
    logic [GAP_W:0]   gcnt;
    logic [GAP_W-1:0] gap_eff;
    logic [GAP_W:0]   gap_last;
    logic             start, gap_done;

    assign gap_eff  = (gap_len < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : gap_len;
    assign gap_last = {gap_eff, 1'b0} - (GAP_W+1)'(1);
    assign start    = en && !fifo_empty;
    assign gap_done = (state == ST_GAP) && half_end && (gcnt == gap_last);

    always_comb begin
        pop = 1'b0;
        if (state == ST_IDLE && start) pop = 1'b1;
        if (gap_done && start)         pop = 1'b1;
    end

    assign running   = (state != ST_IDLE);
    assign line_one  = (state == ST_HIGH) &&  sh.bits[0];
    assign line_zero = (state == ST_HIGH) && !sh.bits[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sh    <= '0;
            gcnt  <= '0;
            eot   <= 1'b0;
        end else begin
            eot <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    sh.bits <= apply_parity(rd_data, par_mode);
                    sh.idx  <= '0;
                    state   <= ST_HIGH;
                end
                ST_HIGH: if (half_end) state <= ST_LOW;
                ST_LOW: if (half_end) begin
                    if (sh.idx == LAST_BIT) begin
                        state <= ST_GAP;
                        gcnt  <= '0;
                        eot   <= fifo_empty;
                    end else begin
                        sh.bits <= sh.bits >> 1;
                        sh.idx  <= sh.idx + 1'b1;
                        state   <= ST_HIGH;
                    end
                end
                ST_GAP: if (half_end) begin
                    if (gcnt == gap_last) begin
                        if (start) begin
                            sh.bits <= apply_parity(rd_data, par_mode);
                            sh.idx  <= '0;
                            state   <= ST_HIGH;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    lines_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(line_one && line_zero));

    // R9
    eot_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eot |=> !eot);

    // R9
    eot_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
        eot |-> (state == ST_GAP) && !line_one && !line_zero);

endmodule

// File: rtl/a429_tx_channel.sv
module a429_tx_channel
    import a429_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       par_mode,
    input  logic [DIV_W-1:0] half_len,
    input  logic [GAP_W-1:0] gap_len,
    output logic             line_one,
    output logic             line_zero,
    output logic             fifo_empty,
    output logic             eot
);
    logic              pop, running, half_end;
    logic [WORD_W-1:0] rd_data;

    a429_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (rd_data),
        .empty   (fifo_empty)
    );

    a429_tx_halftimer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .half_len (half_len),
        .half_end (half_end)
    );

    a429_tx_serializer #(.GAP_W(GAP_W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .half_end   (half_end),
        .fifo_empty (fifo_empty),
        .rd_data    (rd_data),
        .par_mode   (par_mode_e'(par_mode)),
        .gap_len    (gap_len),
        .pop        (pop),
        .running    (running),
        .line_one   (line_one),
        .line_zero  (line_zero),
        .eot        (eot)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> fifo_empty && !eot && !line_one && !line_zero);

endmodule

// File: tb/tb_a429_tx_channel.sv
module tb_a429_tx_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  par_mode = 2'b00;
    logic [15:0] half_len = 16'd2;
    logic [3:0]  gap_len = 4'd4;
    logic        line_one, line_zero, fifo_empty, eot;

    always #2.5 clk = ~clk;

    a429_tx_channel dut (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_data(wr_data),
        .par_mode(par_mode), .half_len(half_len), .gap_len(gap_len),
        .line_one(line_one), .line_zero(line_zero),
        .fifo_empty(fifo_empty), .eot(eot)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int cur_h = 2;
    int cur_g = 4;

    logic [31:0] exp_q[$];

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input logic [31:0] w, input logic [1:0] m);
        int ones = 0;
        logic [31:0] r = w;
        for (int i = 0; i < 31; i++) ones += int'(w[i]);
        if (m == 2'b01) r[31] = (ones % 2 == 0);
        else if (m == 2'b10) r[31] = (ones % 2 == 1);
        return r;
    endfunction

    // driver: writes one word, queues its expected line image if it should be stored
    task automatic push_word(input logic [31:0] w, input bit keep);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        if (keep) exp_q.push_back(model_word(w, par_mode));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor
    logic        prev_act = 1'b0;
    int          run_hi = 0;
    int          run_lo = 100000;
    int          nbits = 0;
    logic [31:0] acc = '0;
    int          words_rx = 0;
    int          last_gap = 0;
    int          eot_cnt = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic act;
            act = line_one | line_zero;
            if (act) begin
                if (!prev_act) begin
                    if (nbits == 0) begin
                        last_gap = run_lo;
                        // R6 minimum spacing between words
                        chk("R6", 32'(run_lo >= (2*cur_g+1)*cur_h), 32'd1);
                    end else begin
                        // R2 return-to-zero half
                        chk("R2", 32'(run_lo), 32'(cur_h));
                    end
                    // R3 bits gathered in index order
                    acc[nbits] = line_one;
                    nbits++;
                    run_hi = 1;
                    if (nbits == 32) begin
                        nbits = 0;
                        words_rx++;
                        if (exp_q.size() == 0) chk("R7", acc, 32'hxxxx_xxxx);
                        else chk("R3", acc, exp_q.pop_front());
                    end
                end else begin
                    run_hi++;
                end
            end else begin
                if (prev_act) begin
                    // R2 high half width (R5 length)
                    chk("R5", 32'(run_hi), 32'(cur_h));
                    run_lo = 1;
                end else begin
                    run_lo++;
                end
            end
            if (eot) begin
                eot_cnt++;
                // R9 pulse only once the queue is drained and the word is whole
                chk("R9", {30'd0, fifo_empty, nbits == 0}, 32'd3);
            end
            prev_act = act;
        end
    end

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || nbits != 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat ((2*cur_g + 4) * cur_h * 2 + 40) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int e0, w0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", {28'd0, line_one, line_zero, fifo_empty, eot}, 32'b0010);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {28'd0, line_one, line_zero, fifo_empty, eot}, 32'b0010);

        // R10: disabled, a queued word waits
        en = 1'b0;
        push_word(32'hA5A5_0F0F, 1);
        // R8 empty flag drops after a write
        chk("R8", 32'(fifo_empty), 32'd0);
        repeat (100) @(negedge clk);
        chk("R10", 32'(words_rx + nbits), 32'd0);
        en = 1'b1;
        drain();
        chk("R4", 32'(words_rx), 32'd1);
        chk("R8", 32'(fifo_empty), 32'd1);

        // R4 odd parity, back-to-back words, exact gap (R6)
        par_mode = 2'b01;
        en = 1'b0;
        e0 = eot_cnt;
        push_word(32'h0000_0001, 1);
        push_word(32'hFFFF_FFFF, 1);
        push_word(32'h1234_5678, 1);
        en = 1'b1;
        drain();
        chk("R6", 32'(last_gap), 32'((2*cur_g+1)*cur_h));
        chk("R9", 32'(eot_cnt - e0), 32'd1);

        // R4 even parity, fastest rate R5 (half_len 0 acts as 1), gap clamp R6
        par_mode = 2'b10;
        half_len = 16'd0; cur_h = 1;
        gap_len  = 4'd2;  cur_g = 4;
        en = 1'b0;
        push_word(32'h8000_0003, 1);
        push_word(32'h7FFF_FFFE, 1);
        en = 1'b1;
        drain();
        chk("R6", 32'(last_gap), 32'((2*cur_g+1)*cur_h));

        // R4 reserved code behaves as none, longer gap and slower rate
        par_mode = 2'b11;
        half_len = 16'd3; cur_h = 3;
        gap_len  = 4'd6;  cur_g = 6;
        en = 1'b0;
        push_word(32'h8000_0000, 1);
        push_word(32'h0000_0000, 1);
        en = 1'b1;
        drain();
        chk("R6", 32'(last_gap), 32'((2*cur_g+1)*cur_h));

        // R7 overfill: ninth write is dropped, order kept
        par_mode = 2'b00;
        half_len = 16'd2; cur_h = 2;
        gap_len  = 4'd4;  cur_g = 4;
        en = 1'b0;
        w0 = words_rx;
        for (int i = 0; i < 9; i++) push_word(32'hC0DE_0000 + 32'(i * 7), i < 8);
        en = 1'b1;
        drain();
        repeat (400) @(negedge clk);
        chk("R7", 32'(words_rx - w0), 32'd8);

        // R10: disabling mid-word completes that word only
        en = 1'b0;
        push_word(32'h5555_AAAA, 1);
        push_word(32'h3333_CCCC, 1);
        en = 1'b1;
        while (nbits < 5) @(negedge clk);
        en = 1'b0;
        w0 = words_rx;
        repeat (600) @(negedge clk);
        chk("R10", 32'(words_rx - w0), 32'd1);
        chk("R10", 32'(exp_q.size()), 32'd1);
        chk("R8", 32'(fifo_empty), 32'd0);
        en = 1'b1;
        drain();
        chk("R8", 32'(fifo_empty), 32'd1);

        finish_run();
    end

endmodule